// File: doc/BRIEF.md
# Merged Program/Data Chip-Enable Router

This block sits between an 8051-style core and its external memory pins. Each bus cycle carries a type (idle, code fetch, data read or data write) and an address. The block registers both. It then matches the address against up to four configurable regions and drives one active-low chip enable for the matching region. It also routes the core's raw read, write and program-store strobes to the pins.

A small control register holds one mode bit per chip enable. With the bit clear, the region is program-only: it answers code fetches and ignores data traffic. With the bit set, the region holds merged program and data memory. Data reads in a merged region are strobed on the program-store pin (PSEN) and not on RD. Data writes to a merged region still use WR. Two things come from a separate configuration input and not from the mode bits: whether each region is enabled, and the inclusive base/limit range it decodes.

Top module: `ce_router`

## Requirements
- R1: The mode register resets to zero. A write with `cfg_we_i` loads mode bits for CE0..CE3 from `cfg_wdata_i` bits 1..4. `cfg_rdata_o` returns those bits in the same positions, and bits 0 and 7:5 always read 0.
- R2: Region i matches when `region_en_i[i]` is 1 and `region_base_i` slice i <= address <= `region_limit_i` slice i. Both bounds are inclusive, and each slice is `ADDR_W` bits wide starting at bit i*ADDR_W.
- R3: A code fetch (cycle type 1) in a matching region drives that region's chip enable low and passes `core_psen_n_i` to `psen_n_o`. This holds whatever the region's mode bit is. `rd_n_o` and `wr_n_o` stay high.
- R4: A data read (cycle type 2) in a matching region with mode bit 1 drives its chip enable low and passes `core_rd_n_i` to `psen_n_o`. `rd_n_o` stays high.
- R5: A data write (cycle type 3) in a matching region with mode bit 1 drives its chip enable low and passes `core_wr_n_i` to `wr_n_o`. `psen_n_o` and `rd_n_o` stay high.
- R6: A data read or write in a matching region with mode bit 0 drives no chip enable and leaves all three strobes high.
- R7: A data read or write that matches no region drives no chip enable. It passes the core's RD or WR strobe to the matching pin, and `psen_n_o` stays high.
- R8: A disabled region's mode bit and range have no effect. An access to that range behaves as one outside every region.
- R9: At most one chip enable is low in any cycle. When ranges overlap, the lowest-numbered matching region is selected, and its own mode bit alone decides the outcome.
- R10: Cycle type and address are registered on the rising clock edge, and the outputs follow the registered values. An idle cycle (type 0) drives every chip enable and strobe high. After reset the registered cycle is idle.
- R11: A code fetch that matches no region passes `core_psen_n_i` to `psen_n_o` and drives no chip enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Mode register write enable |
| cfg_wdata_i | input | 8 | Mode register write data |
| cfg_rdata_o | output | 8 | Mode register read data |
| cyc_type_i | input | 2 | Cycle type: 0 idle, 1 fetch, 2 data read, 3 data write |
| addr_i | input | ADDR_W | Cycle address |
| region_en_i | input | NUM_CE | Per-region enable |
| region_base_i | input | NUM_CE*ADDR_W | Inclusive lower bounds, region i in slice i |
| region_limit_i | input | NUM_CE*ADDR_W | Inclusive upper bounds, region i in slice i |
| core_psen_n_i | input | 1 | Raw program-store strobe from the core |
| core_rd_n_i | input | 1 | Raw data read strobe from the core |
| core_wr_n_i | input | 1 | Raw data write strobe from the core |
| ce_n_o | output | NUM_CE | Active-low chip enables |
| psen_n_o | output | 1 | Program-store strobe pin |
| rd_n_o | output | 1 | Data read strobe pin |
| wr_n_o | output | 1 | Data write strobe pin |

## Verification
The bench goes after data reads to merged regions. If the design keeps RD there, it will show RD and PSEN both low or PSEN stuck high. It also checks data traffic aimed at program-only regions, where a lax design would assert the chip enable or leak RD/WR onto the bus. Overlap cases check lowest-index priority: an inverted priority would select the merged CE3 over the program-only CE2 and assert a chip enable. The bench further covers inclusive limits, disabled regions whose mode bit is set, and the one-edge latency from inputs to pins, because an off-by-one compare, a missing enable gate or an unregistered path each changes the pins visibly.

// File: rtl/ce_router_pkg.sv
package ce_router_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_FETCH  = 2'd1,
    CYC_DREAD  = 2'd2,
    CYC_DWRITE = 2'd3
  } cyc_e;
endpackage

// File: rtl/ce_mode_reg.sv
module ce_mode_reg #(
  parameter int NUM_CE   = 4,
  parameter int CFG_W    = 8,
  parameter int MODE_LSB = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [NUM_CE-1:0] mode_o,
  output logic [CFG_W-1:0]  rdata_o
);
  localparam int MODE_MSB = MODE_LSB + NUM_CE - 1;

  logic [NUM_CE-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i[MODE_MSB:MODE_LSB];
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[MODE_MSB:MODE_LSB] = mode_q;
  end

  assign mode_o = mode_q;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[CFG_W-1:MODE_MSB+1], wdata_i[MODE_LSB-1:0]};
endmodule

// File: rtl/ce_range_decode.sv
module ce_range_decode #(
  parameter int NUM_CE = 4,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NUM_CE-1:0]        en_i,
  input  logic [NUM_CE*ADDR_W-1:0] base_i,
  input  logic [NUM_CE*ADDR_W-1:0] limit_i,
  output logic [NUM_CE-1:0]        hit_o
);
  for (genvar i = 0; i < NUM_CE; i++) begin : g_cmp
    logic [ADDR_W-1:0] lo, hi;
    assign lo       = base_i[i*ADDR_W +: ADDR_W];
    assign hi       = limit_i[i*ADDR_W +: ADDR_W];
    assign hit_o[i] = en_i[i] && (addr_i >= lo) && (addr_i <= hi);
  end
endmodule

// File: rtl/ce_priority_sel.sv
module ce_priority_sel #(
  parameter int NUM_CE = 4
) (
  input  logic [NUM_CE-1:0] req_i,
  output logic [NUM_CE-1:0] gnt_o
);
  logic found;
  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CE; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ce_strobe_steer.sv
module ce_strobe_steer
  import ce_router_pkg::*;
#(
  parameter int NUM_CE = 4
) (
  input  cyc_e              cyc_i,
  input  logic [NUM_CE-1:0] gnt_i,
  input  logic [NUM_CE-1:0] mode_i,
  input  logic              core_psen_n_i,
  input  logic              core_rd_n_i,
  input  logic              core_wr_n_i,
  output logic [NUM_CE-1:0] ce_n_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  logic any_hit, merged_hit;
  assign any_hit    = |gnt_i;
  assign merged_hit = |(gnt_i & mode_i);

  always_comb begin
    ce_n_o   = '1;
    psen_n_o = 1'b1;
    rd_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    unique case (cyc_i)
      CYC_FETCH: begin
        ce_n_o   = ~gnt_i;
        psen_n_o = core_psen_n_i;
      end
      CYC_DREAD: begin
        if (merged_hit) begin
          ce_n_o   = ~gnt_i;
          psen_n_o = core_rd_n_i;
        end else if (!any_hit) begin
          rd_n_o = core_rd_n_i;
        end
      end
      CYC_DWRITE: begin
        if (merged_hit) begin
          ce_n_o = ~gnt_i;
          wr_n_o = core_wr_n_i;
        end else if (!any_hit) begin
          wr_n_o = core_wr_n_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ce_router.sv
module ce_router
  import ce_router_pkg::*;
#(
  parameter int NUM_CE   = 4,
  parameter int ADDR_W   = 16,
  parameter int CFG_W    = 8,
  parameter int MODE_LSB = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [CFG_W-1:0]         cfg_wdata_i,
  output logic [CFG_W-1:0]         cfg_rdata_o,
  input  logic [1:0]               cyc_type_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NUM_CE-1:0]        region_en_i,
  input  logic [NUM_CE*ADDR_W-1:0] region_base_i,
  input  logic [NUM_CE*ADDR_W-1:0] region_limit_i,
  input  logic                     core_psen_n_i,
  input  logic                     core_rd_n_i,
  input  logic                     core_wr_n_i,
  output logic [NUM_CE-1:0]        ce_n_o,
  output logic                     psen_n_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o
);
  cyc_e              cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NUM_CE-1:0] mode_q, hit, gnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_IDLE;
      addr_q <= '0;
    end else begin
      cyc_q  <= cyc_e'(cyc_type_i);
      addr_q <= addr_i;
    end
  end

  ce_mode_reg #(.NUM_CE(NUM_CE), .CFG_W(CFG_W), .MODE_LSB(MODE_LSB)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .mode_o  (mode_q),
    .rdata_o (cfg_rdata_o)
  );

  ce_range_decode #(.NUM_CE(NUM_CE), .ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_q),
    .en_i    (region_en_i),
    .base_i  (region_base_i),
    .limit_i (region_limit_i),
    .hit_o   (hit)
  );

  ce_priority_sel #(.NUM_CE(NUM_CE)) u_sel (
    .req_i (hit),
    .gnt_o (gnt)
  );

  ce_strobe_steer #(.NUM_CE(NUM_CE)) u_steer (
    .cyc_i         (cyc_q),
    .gnt_i         (gnt),
    .mode_i        (mode_q),
    .core_psen_n_i (core_psen_n_i),
    .core_rd_n_i   (core_rd_n_i),
    .core_wr_n_i   (core_wr_n_i),
    .ce_n_o        (ce_n_o),
    .psen_n_o      (psen_n_o),
    .rd_n_o        (rd_n_o),
    .wr_n_o        (wr_n_o)
  );
endmodule

// File: rtl/ce_router_chk.sv
module ce_router_chk #(
  parameter int NUM_CE   = 4,
  parameter int CFG_W    = 8,
  parameter int MODE_LSB = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cyc_q_i,
  input logic [NUM_CE-1:0] mode_q_i,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_rdata_i,
  input logic [NUM_CE-1:0] ce_n_i,
  input logic              psen_n_i,
  input logic              rd_n_i,
  input logic              wr_n_i,
  input logic              core_rd_n_i,
  input logic              core_wr_n_i
);
  logic ce_any;
  assign ce_any = ~&ce_n_i;

  p_one_ce_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_n_i));

  p_rd_quiet_merged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q_i == 2'd2 && ce_any) |-> (rd_n_i && psen_n_i == core_rd_n_i));

  p_wr_merged_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q_i == 2'd3 && ce_any) |-> (wr_n_i == core_wr_n_i && psen_n_i && rd_n_i));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q_i == 2'd0) |-> (!ce_any && psen_n_i && rd_n_i && wr_n_i));

  p_no_dual_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_i && !psen_n_i));

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(mode_q_i));

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_i[MODE_LSB-1:0] == '0 && cfg_rdata_i[CFG_W-1:MODE_LSB+NUM_CE] == '0);
endmodule

bind ce_router ce_router_chk #(.NUM_CE(NUM_CE), .CFG_W(CFG_W), .MODE_LSB(MODE_LSB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_q_i     (cyc_q),
  .mode_q_i    (mode_q),
  .cfg_we_i    (cfg_we_i),
  .cfg_rdata_i (cfg_rdata_o),
  .ce_n_i      (ce_n_o),
  .psen_n_i    (psen_n_o),
  .rd_n_i      (rd_n_o),
  .wr_n_i      (wr_n_o),
  .core_rd_n_i (core_rd_n_i),
  .core_wr_n_i (core_wr_n_i)
);

// File: tb/ce_router_bench.sv
module ce_router_bench;
  localparam int CLK_P  = 10;
  localparam int NUM_CE = 4;
  localparam int ADDR_W = 16;
  localparam int NVEC   = 16;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [1:0] cyc_type = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic [NUM_CE-1:0] reg_en = 4'b1111;
  logic [NUM_CE*ADDR_W-1:0] base, limit;
  logic core_psen_n = 0, core_rd_n = 0, core_wr_n = 0;
  logic [NUM_CE-1:0] ce_n;
  logic psen_n, rd_n, wr_n;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  // CE0 0000-0FFF, CE1 1000-1FFF, CE2 2000-3FFF, CE3 3000-4FFF (CE2/CE3 overlap)
  assign base  = {16'h3000, 16'h2000, 16'h1000, 16'h0000};
  assign limit = {16'h4FFF, 16'h3FFF, 16'h1FFF, 16'h0FFF};

  ce_router u_ce_router (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .cyc_type_i(cyc_type), .addr_i(addr),
    .region_en_i(reg_en), .region_base_i(base), .region_limit_i(limit),
    .core_psen_n_i(core_psen_n), .core_rd_n_i(core_rd_n), .core_wr_n_i(core_wr_n),
    .ce_n_o(ce_n), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n)
  );

  // {type, addr, exp ce_n, exp {psen,rd,wr}}; mode: CE1, CE3 merged; raw strobes low
  localparam logic [24:0] VEC [NVEC] = '{
    {2'd1, 16'h0100, 4'b1110, 3'b011},  // R3 fetch CE0
    {2'd2, 16'h0100, 4'b1111, 3'b111},  // R6 read prog-only
    {2'd3, 16'h0100, 4'b1111, 3'b111},  // R6 write prog-only
    {2'd2, 16'h1800, 4'b1101, 3'b011},  // R4 read merged
    {2'd3, 16'h1800, 4'b1101, 3'b110},  // R5 write merged
    {2'd1, 16'h1800, 4'b1101, 3'b011},  // R3 fetch merged
    {2'd2, 16'h5000, 4'b1111, 3'b101},  // R7 read outside
    {2'd3, 16'h5000, 4'b1111, 3'b110},  // R7 write outside
    {2'd1, 16'h5000, 4'b1111, 3'b011},  // R11 fetch outside
    {2'd2, 16'h3800, 4'b1111, 3'b111},  // R9 overlap, CE2 prog-only wins
    {2'd1, 16'h3800, 4'b1011, 3'b011},  // R9 overlap fetch -> CE2
    {2'd2, 16'h4800, 4'b0111, 3'b011},  // R4 CE3 merged
    {2'd0, 16'h1800, 4'b1111, 3'b111},  // R10 idle
    {2'd1, 16'h2FFF, 4'b1011, 3'b011},  // R2 inside CE2
    {2'd1, 16'h1FFF, 4'b1101, 3'b011},  // R2 inclusive limit
    {2'd1, 16'h1000, 4'b1101, 3'b011}   // R2 inclusive base
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic [1:0] t, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    cyc_type = t;
    addr     = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P*100000);
    n_fail++;
    $display("FAIL R10 watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P*2);
    #1;
    check("R1 reset rdata", {24'd0, cfg_rdata}, 32'h0);
    check("R10 reset outputs", {25'd0, ce_n, psen_n, rd_n, wr_n}, {25'd0, 4'b1111, 3'b111});
    @(negedge clk) rst_ni = 1;

    // R1: all ones written, only bits 4:1 stick
    @(negedge clk); cfg_we = 1; cfg_wdata = 8'hFF;
    @(negedge clk); cfg_we = 0; cfg_wdata = 8'h00;
    check("R1 readback", {24'd0, cfg_rdata}, 32'h1E);
    @(negedge clk); cfg_we = 1; cfg_wdata = 8'b0001_0100; // CE1, CE3 merged
    @(negedge clk); cfg_we = 0;
    check("R1 mode CE1 CE3", {24'd0, cfg_rdata}, 32'h14);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][24:23], VEC[i][22:7]);
      check($sformatf("vec%0d R2-R11 ce_n", i), {28'd0, ce_n}, {28'd0, VEC[i][6:3]});
      check($sformatf("vec%0d strobes", i), {29'd0, psen_n, rd_n, wr_n}, {29'd0, VEC[i][2:0]});
    end

    // R4: PSEN follows raw RD in merged read
    @(negedge clk); core_psen_n = 1; core_rd_n = 1; core_wr_n = 1;
    cycle(2'd2, 16'h1800);
    check("R4 psen follows rd high", {31'd0, psen_n}, 32'd1);
    core_rd_n = 0; #1;
    check("R4 psen follows rd low", {30'd0, psen_n, rd_n}, 32'b01);
    core_rd_n = 1;

    // R8: disable CE1 (merged); read becomes ordinary
    reg_en = 4'b1101; core_rd_n = 0;
    cycle(2'd2, 16'h1800);
    check("R8 disabled region ce", {28'd0, ce_n}, {28'd0, 4'b1111});
    check("R8 disabled region strobes", {29'd0, psen_n, rd_n, wr_n}, {29'd0, 3'b101});
    reg_en = 4'b1111;

    // R10: output holds until the edge
    cycle(2'd1, 16'h0100);
    @(negedge clk); cyc_type = 2'd1; addr = 16'h1800; #1;
    check("R10 pre-edge hold", {28'd0, ce_n}, {28'd0, 4'b1110});
    @(posedge clk); #1;
    check("R10 post-edge", {28'd0, ce_n}, {28'd0, 4'b1101});

    // R1: mode register holds without a write
    @(negedge clk); cfg_wdata = 8'hFF;
    @(negedge clk);
    check("R1 no write hold", {24'd0, cfg_rdata}, 32'h14);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule